// File: doc/BRIEF.md
# SAR Conversion Phase Sequencer

This block is the digital controller for a single successive-approximation analog-to-digital conversion. A one-cycle start request, sent while the block is idle, begins a conversion. The request carries a 2-bit field that sets the length of the final sampling phase. The controller then runs four phases in a fixed order. Each phase raises its own strobe to the analog front end: the mux connects the channel to the sample capacitor, then the buffered capacitor voltage is moved to the DAC array, then the DAC array is charged directly from the mux, and finally the block resolves the bits.

In resolution the block tries one bit per cycle, from the most significant bit down. It drives the trial code on the DAC bus and reads back a one-bit comparator decision. The cycle after the last bit, it gives a one-cycle done pulse, and the 10-bit result stays stable until the next conversion starts.

Top module: `sar_conv_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves every phase strobe, done_o, dac_code_o and result_o at zero, and the block idle.
- R2: start_i is accepted only when the block is idle. A start during a conversion does not change that conversion's timing, its latched sample-time field or its result.
- R3: samp_o goes high the cycle after an accepted start and stays high for exactly 2 cycles.
- R4: xfer_o is high for exactly 4 cycles, beginning the cycle after samp_o falls.
- R5: direct_o is high for 2, 4, 8 or 16 cycles, beginning right after the transfer phase. The length is set by tsel_i latched at start: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 16.
- R6: resolve_o is high for exactly 10 cycles, beginning right after the final sample phase. In resolution cycle k (k = 0..9), dac_code_o equals the bits kept so far OR 1<<(9-k). The trial bit is kept when cmp_i is 1 at the end of that cycle, and cleared otherwise.
- R7: done_o is high for exactly one cycle, on the cycle after the last resolution cycle. result_o then holds the resolved code. From start to done takes 18 to 32 cycles, plus the done cycle, and after done the block is idle.
- R8: At most one of samp_o, xfer_o, direct_o, resolve_o and done_o is high in any cycle. dac_code_o is zero outside resolution.
- R9: result_o is cleared when a start is accepted. Outside resolution it changes only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, honoured only when idle |
| tsel_i | input | 2 | Final sample length select, latched at start |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| samp_o | output | 1 | Initial sample strobe (channel to capacitor) |
| xfer_o | output | 1 | Transfer strobe (buffered capacitor to DAC array) |
| direct_o | output | 1 | Final sample strobe (mux charges DAC array directly) |
| resolve_o | output | 1 | Resolution phase strobe |
| dac_code_o | output | 10 | Trial code for the DAC array |
| result_o | output | 10 | Resolved conversion code |
| done_o | output | 1 | One-cycle conversion complete pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit result, a 2-cycle initial sample, a 4-cycle transfer and a 2-bit sample-time field. With these values all four final sample lengths can be reached, as can the shortest (18-cycle) and longest (32-cycle) conversions. The comparator model resolves input levels at zero, full scale, mid scale, alternating bit patterns and above full scale, so every bit is both kept and cleared in some run. Further runs send a start in the middle of a conversion with a different sample-time field, and pull reset in the middle of a conversion.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  localparam int unsigned SEL_W = 2;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_INIT    = 3'd1,
    PH_XFER    = 3'd2,
    PH_FINAL   = 3'd3,
    PH_RESOLVE = 3'd4,
    PH_DONE    = 3'd5
  } phase_e;

  // Final sample length: 2 << sel (2, 4, 8, 16).
  function automatic int unsigned final_cycles(logic [SEL_W-1:0] sel);
    return 32'd2 << sel;
  endfunction

  function automatic int unsigned phase_cycles(phase_e ph, logic [SEL_W-1:0] sel,
                                               int unsigned init_len,
                                               int unsigned xfer_len,
                                               int unsigned res_len);
    case (ph)
      PH_INIT:    return init_len;
      PH_XFER:    return xfer_len;
      PH_FINAL:   return final_cycles(sel);
      PH_RESOLVE: return res_len;
      default:    return 32'd1;
    endcase
  endfunction

  function automatic phase_e phase_after(phase_e ph);
    case (ph)
      PH_INIT:    return PH_XFER;
      PH_XFER:    return PH_FINAL;
      PH_FINAL:   return PH_RESOLVE;
      PH_RESOLVE: return PH_DONE;
      default:    return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_conv_pkg::*;
#(
  parameter int unsigned INIT_LEN = 2,
  parameter int unsigned XFER_LEN = 4,
  parameter int unsigned RES_LEN  = 10,
  parameter int unsigned CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SEL_W-1:0] tsel_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] step_o,
  output logic             conv_start_o,
  output logic             phase_last_o,
  output logic [SEL_W-1:0] tsel_q_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] tsel_q;
  logic             timed;
  int unsigned      cur_len;

  always_comb begin
    cur_len      = phase_cycles(phase_q, tsel_q, INIT_LEN, XFER_LEN, RES_LEN);
    timed        = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
    phase_last_o = timed && (cnt_q == CNT_W'(cur_len - 1));
    conv_start_o = (phase_q == PH_IDLE) && start_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tsel_q  <= '0;
    end else if (conv_start_o) begin
      phase_q <= PH_INIT;
      cnt_q   <= '0;
      tsel_q  <= tsel_i;
    end else if (!timed) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_last_o) begin
      phase_q <= phase_after(phase_q);
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o  = phase_q;
  assign step_o   = cnt_q;
  assign tsel_q_o = tsel_q;

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic                step_i,
  input  logic [CNT_W-1:0]    step_idx_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic [RES_BITS-1:0] code_o
);

  logic [RES_BITS-1:0] sar_q;
  logic [RES_BITS-1:0] trial;

  // One-hot mask for the bit under test: MSB at step 0.
  function automatic logic [RES_BITS-1:0] bit_mask(logic [CNT_W-1:0] idx);
    logic [RES_BITS-1:0] m;
    for (int i = 0; i < RES_BITS; i++)
      m[i] = (i == (RES_BITS - 1 - int'(idx)));
    return m;
  endfunction

  assign trial = sar_q | bit_mask(step_idx_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i)
      sar_q <= '0;
    else if (step_i && cmp_i)
      sar_q <= trial;
  end

  assign trial_o = step_i ? trial : '0;
  assign code_o  = sar_q;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_pkg::*;
#(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned INIT_LEN = 2,
  parameter int unsigned XFER_LEN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [1:0]          tsel_i,
  input  logic                cmp_i,
  output logic                samp_o,
  output logic                xfer_o,
  output logic                direct_o,
  output logic                resolve_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);

  localparam int unsigned MAX_FINAL = 2 << ((1 << SEL_W) - 1);
  localparam int unsigned MAX_A     = (MAX_FINAL > RES_BITS) ? MAX_FINAL : RES_BITS;
  localparam int unsigned MAX_B     = (INIT_LEN > XFER_LEN) ? INIT_LEN : XFER_LEN;
  localparam int unsigned MAX_LEN   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W     = $clog2(MAX_LEN) + 1;

  phase_e           phase;
  logic [CNT_W-1:0] step;
  logic             conv_start;
  logic             phase_last;
  logic [SEL_W-1:0] tsel_q;

  sar_phase_ctrl #(
    .INIT_LEN (INIT_LEN),
    .XFER_LEN (XFER_LEN),
    .RES_LEN  (RES_BITS),
    .CNT_W    (CNT_W)
  ) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .tsel_i       (tsel_i),
    .phase_o      (phase),
    .step_o       (step),
    .conv_start_o (conv_start),
    .phase_last_o (phase_last),
    .tsel_q_o     (tsel_q)
  );

  sar_bit_engine #(
    .RES_BITS (RES_BITS),
    .CNT_W    (CNT_W)
  ) sar_i (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (conv_start),
    .step_i     (resolve_o),
    .step_idx_i (step),
    .cmp_i      (cmp_i),
    .trial_o    (dac_code_o),
    .code_o     (result_o)
  );

  assign samp_o    = (phase == PH_INIT);
  assign xfer_o    = (phase == PH_XFER);
  assign direct_o  = (phase == PH_FINAL);
  assign resolve_o = (phase == PH_RESOLVE);
  assign done_o    = (phase == PH_DONE);

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int unsigned RES_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                samp_o,
  input logic                xfer_o,
  input logic                direct_o,
  input logic                resolve_o,
  input logic                done_o,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                conv_start,
  input logic [1:0]          tsel_q
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({samp_o, xfer_o, direct_o, resolve_o, done_o})); // R8
  AST_DAC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !resolve_o |-> dac_code_o == '0); // R8
  AST_START_SAMPLES: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> samp_o); // R3
  AST_INIT_SECOND: assert property (@(posedge clk) disable iff (rst)
    (samp_o && !$past(samp_o)) |=> samp_o); // R3
  AST_INIT_END: assert property (@(posedge clk) disable iff (rst)
    (samp_o && $past(samp_o)) |=> xfer_o); // R4
  AST_XFER_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_o) |-> $past(samp_o)); // R4
  AST_FINAL_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(direct_o) |-> $past(xfer_o)); // R5
  AST_RES_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(resolve_o) |-> $past(direct_o)); // R6
  AST_DONE_AFTER_RES: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(resolve_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (start_i && !conv_start) |=> $stable(tsel_q)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!resolve_o && !conv_start) |=> $stable(result_o)); // R9

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_BITS(RES_BITS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .samp_o     (samp_o),
  .xfer_o     (xfer_o),
  .direct_o   (direct_o),
  .resolve_o  (resolve_o),
  .done_o     (done_o),
  .dac_code_o (dac_code_o),
  .result_o   (result_o),
  .conv_start (conv_start),
  .tsel_q     (tsel_q)
);

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] tsel_i = 2'b00;
  logic       cmp_i;
  logic       samp_o, xfer_o, direct_o, resolve_o, done_o;
  logic [9:0] dac_code_o, result_o;

  int vin = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  // Comparator model: input at or above DAC level gives 1.
  assign cmp_i = (vin >= int'(dac_code_o));

  sar_conv_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .tsel_i(tsel_i), .cmp_i(cmp_i),
    .samp_o(samp_o), .xfer_o(xfer_o), .direct_o(direct_o), .resolve_o(resolve_o),
    .dac_code_o(dac_code_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: phase number, cycles left, kept bits, bit under test.
  int m_ph = 0, m_left = 0, m_sar = 0, m_bit = 9, m_fin = 2;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ph = 0; m_sar = 0; m_left = 0;
    end else begin
      case (m_ph)
        0: if (start_i) begin
             m_ph = 1; m_left = 2; m_sar = 0; m_fin = 2 << tsel_i;
           end
        5: m_ph = 0;
        default: begin
          if (m_ph == 4) begin
            if (vin >= (m_sar | (1 << m_bit))) m_sar = m_sar | (1 << m_bit);
            m_bit--;
          end
          m_left--;
          if (m_left == 0) begin
            m_ph++;
            if (m_ph == 2) m_left = 4;
            else if (m_ph == 3) m_left = m_fin;
            else if (m_ph == 4) begin m_left = 10; m_bit = 9; end
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      chk(samp_o == (m_ph == 1), "R3 samp", samp_o, m_ph == 1);
      chk(xfer_o == (m_ph == 2), "R4 xfer", xfer_o, m_ph == 2);
      chk(direct_o == (m_ph == 3), "R5 direct", direct_o, m_ph == 3);
      chk(resolve_o == (m_ph == 4), "R6 resolve", resolve_o, m_ph == 4);
      chk(done_o == (m_ph == 5), "R7 done", done_o, m_ph == 5);
      chk(int'(dac_code_o) == ((m_ph == 4) ? (m_sar | (1 << m_bit)) : 0), "R6 dac",
          dac_code_o, (m_ph == 4) ? (m_sar | (1 << m_bit)) : 0);
      chk(int'(result_o) == m_sar, "R9 result", result_o, m_sar);
    end
  end

  task automatic conv(input int sel, input int v, input bit poke);
    int nd = 0, nr = 0, nb = 0, g = 0, fin, expv;
    fin  = 2 << sel;
    expv = (v > 1023) ? 1023 : v;
    @(negedge clk);
    vin = v; tsel_i = 2'(sel); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && g < 64) begin
      if (direct_o) nd++;
      if (resolve_o) nr++;
      if (samp_o || xfer_o || direct_o || resolve_o) nb++;
      @(negedge clk);
      g++;
      if (poke && g == 3) begin start_i = 1'b1; tsel_i = 2'(~sel); end
      if (poke && g == 4) start_i = 1'b0;
    end
    chk(nd == fin, poke ? "R2 final length after busy start" : "R5 final length", nd, fin);
    chk(nr == 10, "R6 resolution length", nr, 10);
    chk(nb == 16 + fin, "R7 conversion length", nb, 16 + fin);
    chk(done_o && int'(result_o) == expv, "R7 result at done", result_o, expv);
    @(negedge clk);
    chk(!done_o, "R7 done single cycle", done_o, 0);
    chk(int'(result_o) == expv, "R9 result held", result_o, expv);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!samp_o && !xfer_o && !direct_o && !resolve_o && !done_o, "R1 strobes", 1, 0);
    chk(dac_code_o == 0 && result_o == 0, "R1 codes", result_o, 0);
    rst = 1'b0;
    conv(0, 0, 0);
    conv(3, 1023, 0);
    conv(1, 512, 0);
    conv(2, 341, 0);
    conv(0, 682, 0);
    conv(3, 1500, 0);
    conv(1, 1, 0);
    conv(0, 777, 1);
    conv(3, 100, 1);
    // R1: reset in the middle of a conversion
    @(negedge clk);
    vin = 600; tsel_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!samp_o && !xfer_o && !direct_o && !resolve_o && !done_o, "R1 mid strobes", 1, 0);
    chk(dac_code_o == 0 && result_o == 0, "R1 mid codes", result_o, 0);
    rst = 1'b0;
    conv(2, 600, 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule